// File: doc/BRIEF.md
# Sixteen-Point DFT by Row/Column Decomposition

This block computes a 16-point discrete Fourier transform by treating the frame as a 4-by-4 array. A frame of sixteen complex samples arrives one per accepted cycle and is stored in a small array memory. A 4-point DFT then runs over each array row, one row per cycle, and each result is multiplied by a 16-point twiddle factor. A second 4-point DFT then runs over each column, again one per cycle. The spectrum is streamed out in natural bin order. Both short transforms are radix-4, so they need only adds, subtracts and real/imaginary swaps. The only true multiplies are in the twiddle step, which uses a 16-entry cosine table in Q1.15.

The block fits a datapath where a fast stream has already been split into slower parallel paths, and a modest, fixed-latency transform is wanted. Each short-DFT stage divides its result by four, with rounding half up. Every output is therefore the true DFT divided by sixteen, so no stage can overflow for in-range inputs. The block handles one frame at a time. While it transforms or drains a frame it raises `busy`, and it ignores all input.

Top module: `dft16_2d`

## Requirements
- R1: After reset, `out_valid`, `out_sof` and `busy` are all 0.
- R2: A frame begins when `in_valid` and `in_sof` are high together; that sample is index n=0. The next fifteen cycles with `in_valid` high (and `in_sof` low) supply n=1..15 in order. Cycles with `in_valid` low are skipped.
- R3: Output bin k (k=0..15) equals (1/16)·Σ x[n]·e^(−j2πnk/16), with real and imaginary parts each within 3 LSB, in two's-complement 16-bit form.
- R4: The output frame is sixteen consecutive `out_valid` cycles in natural order k=0..15. `out_sof` is high only with bin 0. The first output cycle is the 9th rising edge after the edge that accepted sample 15.
- R5: `busy` is high from the edge that accepts sample 15 until the edge that presents bin 15. While `busy` is high, `in_valid` and `in_sof` are ignored, and the spectrum being emitted is unchanged.
- R6: `in_sof` arriving with `in_valid` while a frame is only partly collected discards the partial frame and restarts at n=0.
- R7: A constant full-scale input (32767 on every sample) gives bin 0 within 3 LSB of 32767 and every other bin within 3 LSB of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_sof | input | 1 | Marks sample n=0 of a frame |
| in_re | input | 16 | Input real part, signed |
| in_im | input | 16 | Input imaginary part, signed |
| busy | output | 1 | Transform or drain in progress; input ignored |
| out_valid | output | 1 | Output bin present |
| out_sof | output | 1 | Marks bin 0 |
| out_re | output | 16 | Output real part, signed, scaled by 1/16 |
| out_im | output | 16 | Output imaginary part, signed, scaled by 1/16 |

## Verification
The output-framing assertions assume that the upstream side follows one rule: a frame is opened only by a sample marked as start-of-frame. The bench always drives `in_sof` on the first sample of every frame it means to transform. It also drives junk (including `in_sof`) only while `busy` is high, and stops driving it before `busy` falls, so no stray frame opens when the block returns to idle. Test amplitudes stay at or below 12000, except in the full-scale constant test. This keeps every intermediate value inside the saturation limits, so the 3-LSB tolerance reflects rounding alone.

// File: rtl/dft16_2d.sv
module dft16_2d #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 busy,
  output logic                 out_valid,
  output logic                 out_sof,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  localparam int N  = 16;
  localparam int CW = 16;
  localparam int AW = DW + CW + 2;
  localparam logic signed [AW-1:0] VMAX = AW'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [AW-1:0] VMIN = -VMAX - AW'(1);

  typedef enum logic [1:0] {IDLE, ROWS, COLS, DRAIN} st_t;
  st_t st;
  logic [3:0] cnt;
  logic       collecting;
  logic signed [DW-1:0] mre [N];
  logic signed [DW-1:0] mim [N];

  function automatic logic signed [DW-1:0] sat(input logic signed [AW-1:0] v);
    if (v > VMAX) return VMAX[DW-1:0];
    if (v < VMIN) return VMIN[DW-1:0];
    return v[DW-1:0];
  endfunction

  function automatic logic signed [CW-1:0] cosq(input logic [3:0] k);
    case (k)
      4'd0:  return 16'sd32767;
      4'd1:  return 16'sd30274;
      4'd2:  return 16'sd23170;
      4'd3:  return 16'sd12540;
      4'd4:  return 16'sd0;
      4'd5:  return -16'sd12540;
      4'd6:  return -16'sd23170;
      4'd7:  return -16'sd30274;
      4'd8:  return -16'sd32767;
      4'd9:  return -16'sd30274;
      4'd10: return -16'sd23170;
      4'd11: return -16'sd12540;
      4'd12: return 16'sd0;
      4'd13: return 16'sd12540;
      4'd14: return 16'sd23170;
      default: return 16'sd30274;
    endcase
  endfunction

  logic [3:0] ad [4];
  logic [3:0] te [4];
  logic signed [AW-1:0] vr [4], vi [4], br [4], bi [4], pr [4], pq [4];
  logic signed [DW-1:0] hr [4], hi [4], rr [4], ri [4];

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      ad[i] = (st == ROWS) ? 4'(int'(cnt[1:0]) + 4*i) : 4'(4*int'(cnt[1:0]) + i);
      vr[i] = AW'(mre[ad[i]]);
      vi[i] = AW'(mim[ad[i]]);
    end
    br[0] = vr[0] + vr[1] + vr[2] + vr[3];
    bi[0] = vi[0] + vi[1] + vi[2] + vi[3];
    br[1] = vr[0] + vi[1] - vr[2] - vi[3];
    bi[1] = vi[0] - vr[1] - vi[2] + vr[3];
    br[2] = vr[0] - vr[1] + vr[2] - vr[3];
    bi[2] = vi[0] - vi[1] + vi[2] - vi[3];
    br[3] = vr[0] - vi[1] - vr[2] + vi[3];
    bi[3] = vi[0] + vr[1] - vi[2] - vr[3];
    for (int q = 0; q < 4; q++) begin
      hr[q] = sat((br[q] + AW'(2)) >>> 2);
      hi[q] = sat((bi[q] + AW'(2)) >>> 2);
      te[q] = 4'(int'(cnt[1:0]) * q);
      pr[q] = AW'(hr[q]) * AW'(cosq(te[q])) + AW'(hi[q]) * AW'(cosq(te[q] - 4'd4));
      pq[q] = AW'(hi[q]) * AW'(cosq(te[q])) - AW'(hr[q]) * AW'(cosq(te[q] - 4'd4));
      rr[q] = (st == ROWS) ? sat((pr[q] + AW'(16384)) >>> 15) : hr[q];
      ri[q] = (st == ROWS) ? sat((pq[q] + AW'(16384)) >>> 15) : hi[q];
    end
  end

  always_ff @(posedge clk) begin
    if (st == IDLE && in_valid && (in_sof || collecting)) begin
      mre[in_sof ? 4'd0 : cnt] <= in_re;
      mim[in_sof ? 4'd0 : cnt] <= in_im;
    end else if (st == ROWS || st == COLS) begin
      for (int q = 0; q < 4; q++) begin
        mre[ad[q]] <= rr[q];
        mim[ad[q]] <= ri[q];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; collecting <= 1'b0;
      out_valid <= 1'b0; out_sof <= 1'b0; out_re <= '0; out_im <= '0;
    end else begin
      out_valid <= (st == DRAIN);
      out_sof   <= (st == DRAIN) && (cnt == 4'd0);
      if (st == DRAIN) begin
        out_re <= mre[{cnt[1:0], cnt[3:2]}];
        out_im <= mim[{cnt[1:0], cnt[3:2]}];
      end
      case (st)
        IDLE: if (in_valid && in_sof) begin
          cnt <= 4'd1; collecting <= 1'b1;
        end else if (in_valid && collecting) begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) begin st <= ROWS; cnt <= '0; collecting <= 1'b0; end
        end
        ROWS:  begin cnt <= cnt + 4'd1; if (cnt == 4'd3) begin st <= COLS; cnt <= '0; end end
        COLS:  begin cnt <= cnt + 4'd1; if (cnt == 4'd3) begin st <= DRAIN; cnt <= '0; end end
        default: begin cnt <= cnt + 4'd1; if (cnt == 4'd15) st <= IDLE; end
      endcase
    end
  end

  assign busy = (st != IDLE);

  a_r4_sof_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  a_r4_frame_opens_with_sof: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sof);
  a_r4_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof) |-> $past(out_valid));
  a_r5_output_under_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy));
  a_r1_idle_no_sof: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_sof);
endmodule

// File: tb/sim_dft16_2d.sv
`timescale 1ns/1ps
module sim_dft16_2d;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic busy, out_valid, out_sof;
  logic signed [15:0] out_re, out_im;
  int n_chk = 0, n_bad = 0;
  int xr [16], xi [16];
  int seed = 12345;

  dft16_2d u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_re(in_re), .in_im(in_im), .busy(busy), .out_valid(out_valid),
    .out_sof(out_sof), .out_re(out_re), .out_im(out_im));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int gap, input int junk_prefix);
    @(negedge clk);
    for (int j = 0; j < junk_prefix; j++) begin
      in_valid = 1'b1; in_sof = (j == 0); in_re = 16'(9000 - j*777); in_im = 16'(j*1111);
      @(negedge clk);
    end
    for (int n = 0; n < 16; n++) begin
      in_valid = 1'b1; in_sof = (n == 0); in_re = 16'(xr[n]); in_im = 16'(xi[n]);
      @(negedge clk);
      if (gap != 0 && n % 3 == 1 && n != 15) begin
        in_valid = 1'b0; in_sof = 1'b0; in_re = 16'h7abc;
        @(negedge clk);
      end
    end
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic collect(input string req, input bit junk);
    int c;
    real er, ei, th;
    chk(busy == 1'b1, "R5", "busy after last sample", int'(busy), 1);
    c = 0;
    while (!out_valid && c < 40) begin
      if (junk) begin in_valid = 1'b1; in_sof = 1'b1; in_re = 16'(c*301 - 5000); in_im = -16'sd3000; end
      @(negedge clk);
      c++;
    end
    chk(c == 9, "R4", "latency to first bin", c, 9);
    for (int k = 0; k < 16; k++) begin
      er = 0.0; ei = 0.0;
      for (int n = 0; n < 16; n++) begin
        th = 2.0 * 3.14159265358979 * n * k / 16.0;
        er += (xr[n] * $cos(th) + xi[n] * $sin(th)) / 16.0;
        ei += (xi[n] * $cos(th) - xr[n] * $sin(th)) / 16.0;
      end
      chk(out_valid == 1'b1, "R4", $sformatf("out_valid bin %0d", k), int'(out_valid), 1);
      chk(out_sof == (k == 0), "R4", $sformatf("out_sof bin %0d", k), int'(out_sof), int'(k == 0));
      chk(int'(out_re) - int'(er) <= 3 && int'(er) - int'(out_re) <= 3, req,
          $sformatf("re bin %0d", k), int'(out_re), int'(er));
      chk(int'(out_im) - int'(ei) <= 3 && int'(ei) - int'(out_im) <= 3, req,
          $sformatf("im bin %0d", k), int'(out_im), int'(ei));
      if (k == 15) begin
        in_valid = 1'b0; in_sof = 1'b0;
        chk(busy == 1'b0, "R5", "busy low with bin 15", int'(busy), 0);
      end else begin
        if (junk) begin in_valid = 1'b1; in_sof = 1'b1; in_re = 16'(k*999); in_im = 16'(-k*555); end
        @(negedge clk);
      end
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R4", "out_valid after frame", int'(out_valid), 0);
  endtask

  task automatic test_reset();
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(out_sof == 1'b0, "R1", "out_sof in reset", int'(out_sof), 0);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && busy == 1'b0, "R1", "idle after reset", int'(out_valid | busy), 0);
  endtask

  task automatic test_impulse();
    for (int n = 0; n < 16; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 8000;
    send(0, 0); collect("R3", 1'b0);
  endtask

  task automatic test_shifted_impulse_gapped();
    for (int n = 0; n < 16; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[5] = 6000; xi[5] = -9000;
    send(1, 0); collect("R2", 1'b0);
  endtask

  task automatic test_tone();
    for (int n = 0; n < 16; n++) begin
      xr[n] = int'(12000.0 * $cos(2.0 * 3.14159265358979 * 3 * n / 16.0));
      xi[n] = int'(12000.0 * $sin(2.0 * 3.14159265358979 * 3 * n / 16.0));
    end
    send(0, 0); collect("R3", 1'b0);
  endtask

  task automatic fill_random();
    for (int n = 0; n < 16; n++) begin
      seed = seed * 1103515245 + 12345;
      xr[n] = ((seed >>> 8) % 24001);
      if (xr[n] < 0) xr[n] = -xr[n];
      xr[n] = xr[n] - 12000;
      seed = seed * 1103515245 + 12345;
      xi[n] = ((seed >>> 8) % 24001);
      if (xi[n] < 0) xi[n] = -xi[n];
      xi[n] = xi[n] - 12000;
    end
  endtask

  task automatic test_random();
    fill_random(); send(0, 0); collect("R3", 1'b0);
  endtask

  task automatic test_busy_ignores_input();
    fill_random(); send(0, 0); collect("R5", 1'b1);
  endtask

  task automatic test_restart();
    fill_random(); send(0, 5); collect("R6", 1'b0);
  endtask

  task automatic test_full_scale();
    for (int n = 0; n < 16; n++) begin xr[n] = 32767; xi[n] = 0; end
    send(0, 0); collect("R7", 1'b0);
  endtask

  bit done = 1'b0;
  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_impulse();
    test_shifted_impulse_gapped();
    test_tone();
    test_random();
    test_busy_ignores_input();
    test_random();
    test_restart();
    test_full_scale();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule